// File: doc/BRIEF.md
# Dual-Channel Converter Command Receiver

This block is the digital front end of a two-channel, 12-bit converter. It receives 16-bit command words over a three-wire serial link in clock-idle-low, sample-on-rising-edge mode: an active-low select, a serial clock and a data line. A faster system clock oversamples all three lines through two-stage synchronizers. Edges of the serial clock and of the select line are detected in the system-clock domain.

Each channel has two levels of storage. A staging register is loaded by commands, and an output register drives the converter. A command can load only the staging register, load it and then copy both staging registers into their output registers, or load the staging and output registers of one channel together. A fourth command group sets a general-purpose logic output, the edge choice for serial readback data, and a shutdown flag. Commands take effect only when the select line is released, and only if exactly sixteen clock edges were seen.

Top module: `dac_cmd_if`

## Requirements
- R1: After reset, both 12-bit output registers, the staging registers, the logic output, the edge select and the shutdown flag are all zero.
- R2: A frame is shifted most significant bit first, one bit on each rising serial clock edge while cs_n is low. Bit 15 is the channel address (0 = channel A, 1 = channel B). Bits 14:13 are the command code. Bits 12:1 are the data, most significant first. Bit 0 is a trailing sub-bit that is ignored.
- R3: While cs_n is high, activity on sclk and din changes no output.
- R4: When cs_n rises after a count of rising clock edges other than 16, the frame is dropped and no output changes.
- R5: Command code 00 loads the addressed staging register only. Neither output register changes.
- R6: Command code 01 loads the addressed staging register and then copies both staging registers into their output registers.
- R7: Command code 10 loads the staging and output registers of the addressed channel. The other channel's output register is unchanged.
- R8: Command code 11 with address 0 sets the logic output to data bit 11 and the readback edge select to data bit 10. Both output registers are unchanged.
- R9: Command code 11 with address 1 sets the shutdown flag to data bit 11. Both output registers are unchanged.
- R10: The effect of a frame appears on the outputs at the fourth system clock rising edge after the edge at which cs_n is first sampled high. Nothing changes before then.
- R11: A frame sent as two 8-bit bursts, with cs_n held low and the serial clock idle low between them, behaves the same as one 16-bit burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in |
| dac_a_o | output | 12 | Channel A output register |
| dac_b_o | output | 12 | Channel B output register |
| logic_out_o | output | 1 | General-purpose logic output |
| dout_edge_o | output | 1 | Readback edge select (0 = falling, 1 = rising) |
| shutdown_o | output | 1 | Shutdown flag |

## Verification
Results are due four system clock edges after the select line is first sampled high. Two of those edges are synchronizer stages, one registers the frame strobe and one registers the decoded update. After each release, the bench waits eight system cycles before it compares every output with its model. That leaves a margin past the due edge and still falls well before the next frame starts. In a directed case, the bench also samples one cycle before the due edge to confirm that nothing has moved yet. The serial clock half period is three system cycles, so every level survives the two synchronizer stages.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int DEF_DATA_W = 12;

    typedef enum logic [1:0] {
        CMD_STAGE      = 2'b00,
        CMD_STAGE_XFER = 2'b01,
        CMD_DIRECT     = 2'b10,
        CMD_SPECIAL    = 2'b11
    } cmd_e;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_s,
    input  logic               sclk_s,
    input  logic               din_s,
    output logic               frm_vld_o,
    output logic [FRAME_W-1:0] frm_o
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_SAT = FRAME_W + 1;

    typedef struct packed {
        logic               sclk_prev;
        logic               cs_prev;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
        logic [FRAME_W-1:0] frm;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_s;
        st_d.vld       = 1'b0;
        if (cs_s) begin
            // release edge: accept only exact-length frames
            if (!st_q.cs_prev && (st_q.cnt == CNT_W'(FRAME_W))) begin
                st_d.vld = 1'b1;
                st_d.frm = st_q.shreg;
            end
            st_d.cnt = '0;
        end else if (sclk_s && !st_q.sclk_prev) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], din_s};
            if (st_q.cnt != CNT_W'(CNT_SAT)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_vld_o = st_q.vld;
    assign frm_o     = st_q.frm;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = DATA_W + 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_vld_i,
    input  logic [FRAME_W-1:0] frm_i,
    output logic [DATA_W-1:0]  dac_a_o,
    output logic [DATA_W-1:0]  dac_b_o,
    output logic               logic_out_o,
    output logic               dout_edge_o,
    output logic               shutdown_o
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] stage;
        logic [NCH-1:0][DATA_W-1:0] dac;
        logic                       uout;
        logic                       edge_sel;
        logic                       sd;
    } bank_t;

    bank_t bk_d, bk_q;

    logic              addr;
    cmd_e              cmd;
    logic [DATA_W-1:0] data;

    assign addr = frm_i[FRAME_W-1];
    assign cmd  = cmd_e'(frm_i[FRAME_W-2 -: 2]);
    assign data = frm_i[DATA_W:1];

    always_comb begin
        bk_d = bk_q;
        if (frm_vld_i) begin
            unique case (cmd)
                CMD_STAGE: begin
                    bk_d.stage[addr] = data;
                end
                CMD_STAGE_XFER: begin
                    bk_d.stage[addr] = data;
                    for (int c = 0; c < NCH; c++) bk_d.dac[c] = bk_d.stage[c];
                end
                CMD_DIRECT: begin
                    bk_d.stage[addr] = data;
                    bk_d.dac[addr]   = data;
                end
                CMD_SPECIAL: begin
                    if (!addr) begin
                        bk_d.uout     = data[DATA_W-1];
                        bk_d.edge_sel = data[DATA_W-2];
                    end else begin
                        bk_d.sd = data[DATA_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bk_q <= '0;
        else     bk_q <= bk_d;
    end

    assign dac_a_o     = bk_q.dac[0];
    assign dac_b_o     = bk_q.dac[1];
    assign logic_out_o = bk_q.uout;
    assign dout_edge_o = bk_q.edge_sel;
    assign shutdown_o  = bk_q.sd;
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [DATA_W-1:0] dac_a_o,
    output logic [DATA_W-1:0] dac_b_o,
    output logic              logic_out_o,
    output logic              dout_edge_o,
    output logic              shutdown_o
);
    localparam int FRAME_W = DATA_W + 4;

    logic [2:0]         pins_s;
    logic               frm_vld;
    logic [FRAME_W-1:0] frm;

    dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({cs_n, sclk, din}),
        .sync_o  (pins_s)
    );

    dac_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .din_s     (pins_s[0]),
        .frm_vld_o (frm_vld),
        .frm_o     (frm)
    );

    dac_reg_bank #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .frm_vld_i   (frm_vld),
        .frm_i       (frm),
        .dac_a_o     (dac_a_o),
        .dac_b_o     (dac_b_o),
        .logic_out_o (logic_out_o),
        .dout_edge_o (dout_edge_o),
        .shutdown_o  (shutdown_o)
    );
endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              frm_vld,
    input logic [DATA_W-1:0] dac_a_o,
    input logic [DATA_W-1:0] dac_b_o,
    input logic              logic_out_o,
    input logic              dout_edge_o,
    input logic              shutdown_o
);
    // R1: one cycle after reset every output reads zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (dac_a_o == '0 && dac_b_o == '0 && !logic_out_o
                        && !dout_edge_o && !shutdown_o));

    // R3: select held high long enough to drain the pipeline freezes outputs
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)
         && $past(cs_n, 4) && $past(cs_n, 5))
        |-> ($stable(dac_a_o) && $stable(dac_b_o) && $stable(logic_out_o)
             && $stable(dout_edge_o) && $stable(shutdown_o)));

    // R10: output registers move only the cycle after a frame strobe
    assert_update_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dac_a_o) || !$stable(dac_b_o) || !$stable(shutdown_o))
        |-> $past(frm_vld));

    // R4: a frame strobe lasts one cycle per release
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> !frm_vld);
endmodule

bind dac_cmd_if dac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .frm_vld     (frm_vld),
    .dac_a_o     (dac_a_o),
    .dac_b_o     (dac_b_o),
    .logic_out_o (logic_out_o),
    .dout_edge_o (dout_edge_o),
    .shutdown_o  (shutdown_o)
);

// File: tb/dac_cmd_if_tb.sv
module dac_cmd_if_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic [11:0] dac_a, dac_b;
    logic uout, edge_sel, sd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model
    logic [11:0] m_stage [2];
    logic [11:0] m_dac   [2];
    logic m_uout, m_edge, m_sd;

    always #5 clk = ~clk;

    dac_cmd_if u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dac_a_o(dac_a), .dac_b_o(dac_b), .logic_out_o(uout),
        .dout_edge_o(edge_sel), .shutdown_o(sd)
    );

    function automatic logic [15:0] mk(input logic a, input logic [1:0] c,
                                       input logic [11:0] d, input logic s);
        return {a, c, d, s};
    endfunction

    function automatic void model_apply(input logic [15:0] w);
        logic a; logic [1:0] c; logic [11:0] d;
        a = w[15]; c = w[14:13]; d = w[12:1];
        case (c)
            2'b00: m_stage[a] = d;
            2'b01: begin
                m_stage[a] = d;
                m_dac[0] = m_stage[0];
                m_dac[1] = m_stage[1];
            end
            2'b10: begin m_stage[a] = d; m_dac[a] = d; end
            default: begin
                if (!a) begin m_uout = d[11]; m_edge = d[10]; end
                else m_sd = d[11];
            end
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, 32'(dac_a), 32'(m_dac[0]));
        chk(req, 32'(dac_b), 32'(m_dac[1]));
        chk(req, 32'({uout, edge_sel, sd}), 32'({m_uout, m_edge, m_sd}));
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nclk rising edges; extra bits beyond 16 are zero
    task automatic send(input logic [15:0] w, input int nclk, input bit split,
                        input bit wait_out);
        cs_n = 1'b0;
        cyc(3);
        for (int k = 0; k < nclk; k++) begin
            din = (k < 16) ? w[15-k] : 1'b0;
            cyc(3);
            sclk = 1'b1;
            cyc(3);
            sclk = 1'b0;
            if (split && k == 7) cyc(10);
        end
        cyc(3);
        cs_n = 1'b1;
        if (wait_out) cyc(8);
    endtask

    task automatic idle_noise(input int n);
        for (int k = 0; k < n; k++) begin
            din = 1'($urandom);
            cyc(3); sclk = 1'b1; cyc(3); sclk = 1'b0;
        end
        cyc(8);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        process::self().srandom(32'd1234);
        for (int i = 0; i < 2; i++) begin m_stage[i] = '0; m_dac[i] = '0; end
        m_uout = 0; m_edge = 0; m_sd = 0;
        cyc(5);
        rst = 1'b0;
        cyc(2);
        chk_all("R1");

        // R5: stage only, outputs hold
        w = mk(0, 2'b00, 12'hABC, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R5");
        w = mk(1, 2'b00, 12'h123, 1'b1); send(w, 16, 0, 1); model_apply(w); chk_all("R5");
        // R6: transfer copies both staging registers
        w = mk(1, 2'b01, 12'h456, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R6");
        chk("R2", 32'(dac_a), 32'h0ABC);
        chk("R6", 32'(dac_b), 32'h0456);
        // R7: direct load, other channel untouched
        w = mk(0, 2'b10, 12'h801, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R7");
        chk("R7", 32'(dac_b), 32'h0456);
        // R8 and R9
        w = mk(0, 2'b11, 12'h800, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R8");
        w = mk(0, 2'b11, 12'h400, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R8");
        w = mk(1, 2'b11, 12'h800, 1'b0); send(w, 16, 0, 1); model_apply(w); chk_all("R9");
        chk("R9", 32'(sd), 32'd1);
        // R4: short and long frames dropped
        send(mk(0, 2'b10, 12'hFFF, 1'b1), 15, 0, 1); chk_all("R4");
        send(mk(1, 2'b10, 12'hFFF, 1'b1), 17, 0, 1); chk_all("R4");
        // R3: clock activity with select high
        idle_noise(20); chk_all("R3");
        // R11: split transfer
        w = mk(1, 2'b10, 12'h5A5, 1'b0); send(w, 16, 1, 1); model_apply(w); chk_all("R11");
        // R10: latency, not yet at third edge, present at fourth
        w = mk(0, 2'b10, 12'h3C3, 1'b0);
        send(w, 16, 0, 0);           // cs_n rose at a negedge
        cyc(3);                      // sampled high at edge 1, now after edge 3
        chk("R10", 32'(dac_a), 32'(m_dac[0]));
        model_apply(w);
        cyc(1);
        chk("R10", 32'(dac_a), 32'(m_dac[0]));
        cyc(4);

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            int sel;
            w = 16'($urandom);
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                send(w, 15 - int'($urandom_range(0, 3)), 0, 1);
                chk_all("R4");
            end else if (sel == 1) begin
                idle_noise(5); chk_all("R3");
            end else begin
                send(w, 16, sel == 2, 1);
                model_apply(w);
                chk_all("R2");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule